// File: doc/BRIEF.md
# Frame Peak Locator with Double-Buffered Frame Store

This block accepts a stream of unsigned 16-bit samples that make up square maps of 20 rows by 20 columns. One sample arrives per qualified clock, and the samples come in row-major order: the column advances first, and the row advances when the column wraps. While a map streams in, the block tracks the largest sample seen so far together with its row and column. When the final sample of the map is accepted, it publishes the map's peak value and location for one cycle.

Each sample is also written into one of two internal banks. In the same cycle, the sample stored at the same row and column in the previous map is read from the other bank. This sample is presented one cycle later with its own valid strobe and position. At every map boundary the two banks trade roles. Downstream logic therefore receives the previous map in scan order, at the input rate, and its peak location is already known before that map starts to replay.

Top module: `frame_peak_store`

## Requirements
- R1: While reset is held and right after it, `frm_done` and `rd_valid` are 0 and `frm_max`, `frm_row`, `frm_col`, `rd_data`, `rd_row` and `rd_col` are all 0.
- R2: `frm_done` is high for exactly one cycle, in the cycle after the 400th accepted sample of a map, and at no other time.
- R3: When `frm_done` is high, `frm_max` equals the largest value of that map, with samples compared as unsigned 16-bit numbers.
- R4: When several samples share the largest value, `frm_row`/`frm_col` give the earliest of them in row-major scan order, because only a strictly greater sample replaces the current leader.
- R5: A cycle with `in_valid` low has no effect. Its `in_data` does not enter the peak search, the store or the position count, and `rd_valid` is 0 in the following cycle.
- R6: From reset until one full map has been accepted, `rd_valid` stays 0.
- R7: Once a full map has been stored, each accepted sample at (r, c) causes `rd_valid` to be 1 in the next cycle, with `rd_data` equal to the sample accepted at (r, c) in the preceding map.
- R8: Between two `frm_done` pulses, `frm_max`, `frm_row` and `frm_col` hold the values published at the last pulse.
- R9: Positions are counted row-major from (0,0), with the column running 0..19 before the row advances and both wrapping to 0 after (19,19). `rd_row`/`rd_col` report the position of the replayed sample, and `frm_row`/`frm_col` use the same coordinates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | 16 | Unsigned sample |
| frm_done | output | 1 | One-cycle pulse after the last sample of a map |
| frm_max | output | 16 | Peak value of the most recently completed map |
| frm_row | output | 5 | Row of that peak |
| frm_col | output | 5 | Column of that peak |
| rd_valid | output | 1 | Replayed sample from the previous map is valid |
| rd_data | output | 16 | Replayed sample |
| rd_row | output | 5 | Row of the replayed sample |
| rd_col | output | 5 | Column of the replayed sample |

## Verification
Closing a map, publishing its peak and swapping the banks all happen in the cycle in which the 400th sample is accepted. That same sample may also be the new peak, and the sample accepted in the next cycle must already be read back from the bank that was just filled. The stimulus provokes this collision in several ways: a map whose largest value sits at (19,19), maps with idle cycles whose ignored data is larger than any real sample, and back-to-back maps with no gap. The bench judges the collision by the value and position reported on the pulse and by the first replayed sample of the next map, which must come from the map that just closed. Ties are provoked the same way, with an all-zero map and maps that contain two equal peaks in different orders.

// File: rtl/fmx_pkg.sv
package fmx_pkg;

  localparam int unsigned FMX_DATA_W = 16;
  localparam int unsigned FMX_ROWS   = 20;
  localparam int unsigned FMX_COLS   = 20;

  // Unsigned strict comparison built on the borrow of a subtraction:
  // a > b when a - b produces no borrow and a nonzero difference.
  function automatic logic fmx_gt(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] diff;
    diff = {1'b0, a} - {1'b0, b};
    return (diff[32] == 1'b0) && (diff[31:0] != 32'd0);
  endfunction

  // Linear address of a (row, col) position in row-major order.
  function automatic int unsigned fmx_addr(input int unsigned row,
                                           input int unsigned col,
                                           input int unsigned cols);
    return row * cols + col;
  endfunction

endpackage

// File: rtl/fmx_scan.sv
module fmx_scan #(
  parameter int ROWS  = 20,
  parameter int COLS  = 20,
  parameter int ROW_W = 5,
  parameter int COL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             at_last
);

  logic col_end;
  logic row_end;

  assign col_end = (col == COL_W'(COLS - 1));
  assign row_end = (row == ROW_W'(ROWS - 1));
  assign at_last = col_end && row_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else if (adv) begin
      if (col_end) begin
        col <= '0;
        row <= row_end ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (row < ROW_W'(ROWS)) && (col < COL_W'(COLS))); // R9

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !col_end) |=> (col == COL_W'($past(col) + 1'b1)) && $stable(row)); // R9

  AST_MAP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_last) |=> (row == '0) && (col == '0)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(row) && $stable(col)); // R5

endmodule

// File: rtl/fmx_argmax.sv
module fmx_argmax #(
  parameter int DATA_W = 16,
  parameter int ROW_W  = 5,
  parameter int COL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] sample,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic              at_last,
  output logic              done,
  output logic [DATA_W-1:0] res_max,
  output logic [ROW_W-1:0]  res_row,
  output logic [COL_W-1:0]  res_col
);

  logic [DATA_W-1:0] lead_val;
  logic [ROW_W-1:0]  lead_row;
  logic [COL_W-1:0]  lead_col;
  logic              lead_open;
  logic              beats_lead;
  logic              new_lead;
  logic              closing;

  // A sample becomes the leader when it is strictly greater than the current
  // leader, or when it is the first sample of the map.
  assign beats_lead = fmx_pkg::fmx_gt(32'(sample), 32'(lead_val));
  assign new_lead   = take && (!lead_open || beats_lead);
  assign closing    = take && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lead_val  <= '0;
      lead_row  <= '0;
      lead_col  <= '0;
      lead_open <= 1'b0;
      done      <= 1'b0;
      res_max   <= '0;
      res_row   <= '0;
      res_col   <= '0;
    end else begin
      done <= closing;
      if (closing) begin
        lead_open <= 1'b0;
        res_max   <= new_lead ? sample : lead_val;
        res_row   <= new_lead ? row    : lead_row;
        res_col   <= new_lead ? col    : lead_col;
      end else if (take) begin
        lead_open <= 1'b1;
        if (new_lead) begin
          lead_val <= sample;
          lead_row <= row;
          lead_col <= col;
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(res_max) && $stable(res_row) && $stable(res_col)); // R8

  AST_LEAD_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !at_last && lead_open) |=> (lead_val >= $past(lead_val))); // R3

  AST_TIE_KEEPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !at_last && lead_open && (sample == lead_val))
      |=> $stable(lead_row) && $stable(lead_col)); // R4

  AST_PEAK_COVERS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    closing |=> (res_max >= $past(sample))); // R3

endmodule

// File: rtl/fmx_pingpong.sv
module fmx_pingpong #(
  parameter int DATA_W = 16,
  parameter int ROWS   = 20,
  parameter int COLS   = 20,
  parameter int ROW_W  = 5,
  parameter int COL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic              swap,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ROW_W-1:0]  rd_row,
  output logic [COL_W-1:0]  rd_col
);

  localparam int DEPTH  = ROWS * COLS;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int BANKS  = 2;

  logic              wr_sel;
  logic              filled;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] bank_rd [BANKS];

  assign addr = ADDR_W'(fmx_pkg::fmx_addr(32'(row), 32'(col), COLS));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_sel == 1'(b))) mem[addr] <= wr_data;
    end
    assign bank_rd[b] = mem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_sel   <= 1'b0;
      filled   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_row   <= '0;
      rd_col   <= '0;
    end else begin
      rd_valid <= wr_en && filled;
      if (wr_en) begin
        rd_data <= bank_rd[!wr_sel];
        rd_row  <= row;
        rd_col  <= col;
        if (swap) begin
          wr_sel <= !wr_sel;
          filled <= 1'b1;
        end
      end
    end
  end

  AST_RD_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(wr_en)); // R7

  AST_BANK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && swap) |=> (wr_sel != $past(wr_sel))); // R7

  AST_BANK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && swap) |=> $stable(wr_sel)); // R7

  AST_QUIET_UNTIL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !filled |-> !rd_valid); // R6

  AST_IDLE_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !rd_valid); // R5

endmodule

// File: rtl/frame_peak_store.sv
module frame_peak_store #(
  parameter int DATA_W = fmx_pkg::FMX_DATA_W,
  parameter int ROWS   = fmx_pkg::FMX_ROWS,
  parameter int COLS   = fmx_pkg::FMX_COLS,
  parameter int ROW_W  = $clog2(ROWS),
  parameter int COL_W  = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              frm_done,
  output logic [DATA_W-1:0] frm_max,
  output logic [ROW_W-1:0]  frm_row,
  output logic [COL_W-1:0]  frm_col,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ROW_W-1:0]  rd_row,
  output logic [COL_W-1:0]  rd_col
);

  // Named internal events, shared by the sub-blocks and the assertions.
  logic             accept;
  logic             frame_last;
  logic             frame_swap;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;

  assign accept     = in_valid;
  assign frame_swap = accept && frame_last;

  fmx_scan #(
    .ROWS (ROWS),
    .COLS (COLS),
    .ROW_W(ROW_W),
    .COL_W(COL_W)
  ) u_scan (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (accept),
    .row    (cur_row),
    .col    (cur_col),
    .at_last(frame_last)
  );

  fmx_argmax #(
    .DATA_W(DATA_W),
    .ROW_W (ROW_W),
    .COL_W (COL_W)
  ) u_argmax (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (accept),
    .sample (in_data),
    .row    (cur_row),
    .col    (cur_col),
    .at_last(frame_last),
    .done   (frm_done),
    .res_max(frm_max),
    .res_row(frm_row),
    .res_col(frm_col)
  );

  fmx_pingpong #(
    .DATA_W(DATA_W),
    .ROWS  (ROWS),
    .COLS  (COLS),
    .ROW_W (ROW_W),
    .COL_W (COL_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_data (in_data),
    .row     (cur_row),
    .col     (cur_col),
    .swap    (frame_swap),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .rd_row  (rd_row),
    .rd_col  (rd_col)
  );

  AST_DONE_AFTER_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> $past(frame_swap)); // R2

  AST_SWAP_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_swap |=> frm_done); // R2

  AST_RD_POS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_row == $past(cur_row)) && (rd_col == $past(cur_col))); // R9

endmodule

// File: tb/frame_peak_store_tb.sv
module frame_peak_store_tb;

  localparam int NR = 20;
  localparam int NC = 20;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        frm_done;
  logic [15:0] frm_max;
  logic [4:0]  frm_row;
  logic [4:0]  frm_col;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [4:0]  rd_row;
  logic [4:0]  rd_col;

  frame_peak_store u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .frm_done(frm_done), .frm_max(frm_max), .frm_row(frm_row), .frm_col(frm_col),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_row(rd_row), .rd_col(rd_col)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [7:0]  seed;
    logic [15:0] peak;
    logic [4:0]  pr;
    logic [4:0]  pc;
    logic        tie;
    logic [4:0]  tr;
    logic [4:0]  tc;
    logic [3:0]  gap;
    logic [4:0]  er;
    logic [4:0]  ec;
  } vec_t;

  // seed, peak, peak pos, tie flag, tie pos, idle spacing, expected pos
  localparam vec_t VECS [5] = '{
    '{8'd1, 16'h8000, 5'd7,  5'd11, 1'b0, 5'd0,  5'd0,  4'd0, 5'd7,  5'd11},
    '{8'd2, 16'h1234, 5'd3,  5'd4,  1'b1, 5'd12, 5'd0,  4'd3, 5'd3,  5'd4 },
    '{8'd3, 16'hABCD, 5'd15, 5'd2,  1'b1, 5'd0,  5'd19, 4'd0, 5'd0,  5'd19},
    '{8'd4, 16'h7FFF, 5'd19, 5'd19, 1'b0, 5'd0,  5'd0,  4'd5, 5'd19, 5'd19},
    '{8'd5, 16'h1000, 5'd0,  5'd0,  1'b1, 5'd0,  5'd1,  4'd2, 5'd0,  5'd0 }
  };

  int checks = 0;
  int errors = 0;

  // bench reference state
  int          prev_map [NR*NC];
  bit          have_prev;
  int          br, bc;
  logic [15:0] exp_max;
  int          exp_row, exp_col;
  string       frame_tag;

  bit          pend_done;
  logic [15:0] pend_max;
  int          pend_row, pend_col;
  logic [15:0] held_max;
  int          held_row, held_col;
  bit          pend_rdv;
  int          pend_rdd, pend_rdr, pend_rdc;
  string       pend_rdtag;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_pending();
    chk("R2", "frm_done", int'(frm_done), int'(pend_done));
    if (pend_done) begin
      chk(frame_tag, "frm_max", int'(frm_max), int'(pend_max));
      chk("R4", "frm_row", int'(frm_row), pend_row);
      chk("R4", "frm_col", int'(frm_col), pend_col);
      held_max = pend_max;
      held_row = pend_row;
      held_col = pend_col;
    end else begin
      chk("R8", "frm_max held", int'(frm_max), int'(held_max));
      chk("R8", "frm_row held", int'(frm_row), held_row);
      chk("R8", "frm_col held", int'(frm_col), held_col);
    end
    chk(pend_rdtag, "rd_valid", int'(rd_valid), int'(pend_rdv));
    if (pend_rdv) begin
      chk("R7", "rd_data", int'(rd_data), pend_rdd);
      chk("R9", "rd_row", int'(rd_row), pend_rdr);
      chk("R9", "rd_col", int'(rd_col), pend_rdc);
    end
  endtask

  // temporary map being built by the current frame
  int cur_map [NR*NC];

  task automatic tick(input logic v, input logic [15:0] d);
    @(negedge clk);
    check_pending();
    in_valid = v;
    in_data  = d;
    pend_done = 1'b0;
    pend_rdv  = v && have_prev;
    pend_rdtag = !v ? "R5" : (have_prev ? "R7" : "R6");
    if (v) begin
      pend_rdd = prev_map[br*NC + bc];
      pend_rdr = br;
      pend_rdc = bc;
      cur_map[br*NC + bc] = int'(d);
      if (br == NR-1 && bc == NC-1) begin
        pend_done = 1'b1;
        pend_max  = exp_max;
        pend_row  = exp_row;
        pend_col  = exp_col;
        for (int k = 0; k < NR*NC; k++) prev_map[k] = cur_map[k];
        have_prev = 1'b1;
        br = 0;
        bc = 0;
      end else if (bc == NC-1) begin
        bc = 0;
        br = br + 1;
      end else begin
        bc = bc + 1;
      end
    end
  endtask

  function automatic logic [15:0] bg(input int seed, input int r, input int c);
    if (seed == 0) return 16'd0;
    return 16'((seed*613 + r*97 + c*31) & 12'hFFF);
  endfunction

  task automatic send_frame(input int seed, input logic [15:0] peak, input int pr, input int pc,
                            input bit tie, input int tr, input int tc, input int gap,
                            input int er, input int ec, input string tag);
    int n;
    exp_max   = peak;
    exp_row   = er;
    exp_col   = ec;
    frame_tag = tag;
    n = 0;
    for (int r = 0; r < NR; r++) begin
      for (int c = 0; c < NC; c++) begin
        logic [15:0] d;
        d = bg(seed, r, c);
        if ((r == pr && c == pc) || (tie && r == tr && c == tc)) d = peak;
        tick(1'b1, d);
        n++;
        // idle cycles carry large junk that must be ignored (R5)
        if (gap != 0 && (n % gap) == 0) tick(1'b0, 16'hFFFF);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    check_pending();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = 16'hFFFF;
    pend_done = 1'b0;
    pend_rdv  = 1'b0;
    pend_rdtag = "R6";
    have_prev = 1'b0;
    br = 0;
    bc = 0;
    held_max = '0;
    held_row = 0;
    held_col = 0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R1", "frm_done", int'(frm_done), 0);
      chk("R1", "rd_valid", int'(rd_valid), 0);
      chk("R1", "frm_max", int'(frm_max), 0);
      chk("R1", "frm_row", int'(frm_row), 0);
      chk("R1", "frm_col", int'(frm_col), 0);
      chk("R1", "rd_data", int'(rd_data), 0);
      chk("R1", "rd_row", int'(rd_row), 0);
      chk("R1", "rd_col", int'(rd_col), 0);
    end
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    pend_rdtag = "R6";
    frame_tag = "R3";
    for (int k = 0; k < NR*NC; k++) begin
      prev_map[k] = 0;
      cur_map[k] = 0;
    end
    do_reset();

    // table-driven maps, back to back; first one has no replay (R6)
    for (int i = 0; i < 5; i++) begin
      send_frame(int'(VECS[i].seed), VECS[i].peak, int'(VECS[i].pr), int'(VECS[i].pc),
                 VECS[i].tie, int'(VECS[i].tr), int'(VECS[i].tc), int'(VECS[i].gap),
                 int'(VECS[i].er), int'(VECS[i].ec), VECS[i].tie ? "R4" : "R3");
    end

    // all-zero map: every sample ties, earliest (0,0) wins (R4)
    send_frame(0, 16'h0000, 5, 5, 1'b0, 0, 0, 0, 0, 0, "R4");
    // full-scale peak on the closing sample (R3)
    send_frame(9, 16'hFFFF, 19, 19, 1'b0, 0, 0, 0, 19, 19, "R3");
    // idle stretch: results hold, nothing replays (R5, R8)
    for (int i = 0; i < 6; i++) tick(1'b0, 16'hFFFF);

    // reset in the middle of a map
    for (int i = 0; i < 150; i++) tick(1'b1, 16'(i));
    do_reset();
    send_frame(6, 16'h4242, 10, 10, 1'b0, 0, 0, 0, 10, 10, "R3");
    send_frame(7, 16'h5000, 2, 18, 1'b1, 2, 17, 4, 2, 17, "R4");
    tick(1'b0, 16'h0000);
    tick(1'b0, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule